// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It reads translation entries from a two-level table that sits in ordinary memory. A requester hands over one address at a time, together with a write flag and a user-mode flag. The walker then fetches the directory entry and, when that entry points at a second-level table, the table entry as well. It uses a memory read port that has one request in flight at most. When the walk ends it raises a one-cycle done pulse. The pulse carries either the physical address or a fault flag with a two-bit cause.

The directory location is taken from the upper 20 bits of a base register. The low 12 bits of that register are ignored. Directory entries may map a 4 MB region directly when large pages are enabled, so 4 MB and 4 KB mappings can be mixed in one directory. When paging is switched off, the address passes through unchanged and no memory traffic takes place. Caching of translations and updates to entry flags are not part of this block.

Top module: `page_walker`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1, and `doneValid` and `memReqValid` are 0.
- R2: A request accepted while `pagingOn` is 0 completes with `donePhys` equal to the linear address, `doneFault` 0 and `doneCause` 0. `doneValid` is raised in the cycle after acceptance, and no memory read is issued.
- R3: A 4 KB walk issues exactly two reads, in this order:
  - the directory entry, at `{dirBase[31:12],12'b0} + linear[31:22]*4`;
  - the table entry, at `{pde[31:12],12'b0} + linear[21:12]*4`.
  The result is `{pte[31:12], linear[11:0]}`.
- R4: A directory entry whose bit 0 (present) is 0 ends the walk after one read. The result is `doneFault` 1 with `doneCause` 1 (not present) and `donePhys` 0.
- R5: A present directory entry followed by a table entry whose bit 0 is 0 ends after two reads. The result is `doneFault` 1 with `doneCause` 1.
- R6: With `bigPageOn` 1, a present directory entry with bit 7 set ends the walk after one read. The result is `{pde[31:22], linear[21:0]}`.
- R7: With `bigPageOn` 0, bit 7 of a directory entry is ignored and the entry is used as a table pointer. This gives two reads.
- R8: A user-mode access (`reqUser`=1) to a leaf whose effective bit 2 (user allowed) is 0 faults with `doneCause` 2. The same access in supervisor mode succeeds.
- R9: A user-mode write to a leaf whose effective bit 1 (writable) is 0 faults with `doneCause` 3. A user read of that leaf, or a supervisor write to it, succeeds. When both checks fail, cause 2 wins.
- R10: For 4 KB pages the effective bit 1 and bit 2 are the AND of the directory entry bit and the table entry bit.
- R11: The walker waits any number of cycles for `memReqReady` and for `memRspValid`. It holds `memReqValid` and `memReqAddr` steady until the request is taken.
- R12: Only one translation is in progress at a time. `reqReady` is 0 from acceptance until the done pulse, and `doneValid` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request taken when both are high |
| reqAddr | input | 32 | Linear address to translate |
| reqWrite | input | 1 | Access is a write |
| reqUser | input | 1 | Access is made in user mode |
| dirBase | input | 32 | Base register, upper 20 bits locate the directory |
| pagingOn | input | 1 | Translation enable, sampled at acceptance |
| bigPageOn | input | 1 | 4 MB page enable, sampled at acceptance |
| doneValid | output | 1 | One-cycle completion pulse |
| donePhys | output | 32 | Physical address, 0 on fault |
| doneFault | output | 1 | Translation faulted |
| doneCause | output | 2 | 0 none, 1 not present, 2 privilege, 3 write-protect |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory takes the request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | 32 | Returned entry |

## Verification
The hardest case to reach is the rights check on a 4 KB page that combines two entries. The directory entry denies user access while the table entry allows it, so the fault can only come from combining both levels. The bench builds a sparse memory image in which one directory entry lacks the user bit and points at a table whose entry has every right. A user read through it must then fault. A second case uses the same directory entry with bit 7 set while large pages are disabled. It shows that the size bit is only honoured under the enable, because the walk goes on to a second read at the table address the entry encodes. The memory responder also holds back ready and data for several cycles, to reach the waiting states with the request held.

// File: rtl/page_walk_pkg.sv
package page_walk_pkg;

  // Flag bit positions inside a translation entry
  localparam int FLAG_PRESENT = 0;
  localparam int FLAG_WRITE   = 1;
  localparam int FLAG_USER    = 2;
  localparam int FLAG_BIG     = 7;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'd0,
    CAUSE_ABSENT = 2'd1,
    CAUSE_PRIV   = 2'd2,
    CAUSE_WPROT  = 2'd3
  } faultCause_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureReq;    // latch request fields
    logic finishBypass;  // paging off: result is the raw address
    logic keepDir;       // latch directory entry for the second level
    logic finishDir;     // leaf reached at directory (large page)
    logic finishTbl;     // leaf reached at table
    logic finishAbsent;  // not-present fault
    logic selTable;      // memory address selects second level
  } walkStrobes_t;

  // Privilege has priority over write protection
  function automatic faultCause_t judgeRights(input logic userOk,
                                              input logic writeOk,
                                              input logic isUser,
                                              input logic isWrite);
    if (isUser && !userOk)
      return CAUSE_PRIV;
    else if (isUser && isWrite && !writeOk)
      return CAUSE_WPROT;
    else
      return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/page_walk_ctrl.sv
module page_walk_ctrl
  import page_walk_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         pagingOn,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         rspPresent,
  input  logic         rspBig,
  output logic         reqReady,
  output logic         memReqValid,
  output logic         doneValid,
  output walkStrobes_t strobes
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_TBL_REQ, ST_TBL_WAIT, ST_DONE
  } walkState_t;

  walkState_t stateQ, stateD;
  logic       accept;

  assign accept = reqValid && (stateQ == ST_IDLE);

  always_comb begin
    stateD  = stateQ;
    strobes = '0;
    strobes.selTable = (stateQ == ST_TBL_REQ);
    unique case (stateQ)
      ST_IDLE: begin
        if (accept) begin
          strobes.captureReq = 1'b1;
          if (!pagingOn) begin
            strobes.finishBypass = 1'b1;
            stateD = ST_DONE;
          end else begin
            stateD = ST_DIR_REQ;
          end
        end
      end
      ST_DIR_REQ:  if (memReqReady) stateD = ST_DIR_WAIT;
      ST_DIR_WAIT: begin
        if (memRspValid) begin
          if (!rspPresent) begin
            strobes.finishAbsent = 1'b1;
            stateD = ST_DONE;
          end else if (rspBig) begin
            strobes.finishDir = 1'b1;
            stateD = ST_DONE;
          end else begin
            strobes.keepDir = 1'b1;
            stateD = ST_TBL_REQ;
          end
        end
      end
      ST_TBL_REQ:  if (memReqReady) stateD = ST_TBL_WAIT;
      ST_TBL_WAIT: begin
        if (memRspValid) begin
          if (!rspPresent) strobes.finishAbsent = 1'b1;
          else             strobes.finishTbl    = 1'b1;
          stateD = ST_DONE;
        end
      end
      ST_DONE:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = (stateQ == ST_DIR_REQ) || (stateQ == ST_TBL_REQ);
  assign doneValid   = (stateQ == ST_DONE);

endmodule

// File: rtl/page_walk_datapath.sv
module page_walk_datapath
  import page_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int TBL_W  = 10,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobes_t      strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              bigPageOn,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              rspPresent,
  output logic              rspBig,
  output logic [ADDR_W-1:0] donePhys,
  output logic              doneFault,
  output logic [1:0]        doneCause
);

  localparam int BIG_W   = OFF_W + TBL_W;       // offset width of a large page
  localparam int DIR_W   = ADDR_W - BIG_W;      // directory index width
  localparam int FRAME_W = ADDR_W - OFF_W;      // frame number width

  logic [ADDR_W-1:0]  addrQ;
  logic               writeQ, userQ, bigEnQ;
  logic [FRAME_W-1:0] baseQ;
  logic [ADDR_W-1:0]  dirEntryQ;
  logic [ADDR_W-1:0]  physQ;
  logic               faultQ;
  faultCause_t        causeQ;

  logic [DIR_W-1:0]   dirIdx;
  logic [TBL_W-1:0]   tblIdx;
  logic [ADDR_W-1:0]  dirSlot, tblSlot;
  faultCause_t        dirVerdict, tblVerdict;
  logic [ADDR_W-1:0]  bigPhys, smallPhys;

  assign dirIdx = addrQ[ADDR_W-1:BIG_W];
  assign tblIdx = addrQ[BIG_W-1:OFF_W];

  assign dirSlot = {baseQ, {OFF_W{1'b0}}} + (ADDR_W'(dirIdx) << ENTRY_SHIFT);
  assign tblSlot = {dirEntryQ[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                 + (ADDR_W'(tblIdx) << ENTRY_SHIFT);
  assign memReqAddr = strobes.selTable ? tblSlot : dirSlot;

  assign rspPresent = memRspData[FLAG_PRESENT];
  assign rspBig     = bigEnQ && memRspData[FLAG_BIG];

  // Rights: directory alone for a large page, both levels ANDed otherwise
  assign dirVerdict = judgeRights(memRspData[FLAG_USER], memRspData[FLAG_WRITE],
                                  userQ, writeQ);
  assign tblVerdict = judgeRights(memRspData[FLAG_USER] & dirEntryQ[FLAG_USER],
                                  memRspData[FLAG_WRITE] & dirEntryQ[FLAG_WRITE],
                                  userQ, writeQ);

  assign bigPhys   = {memRspData[ADDR_W-1:BIG_W], addrQ[BIG_W-1:0]};
  assign smallPhys = {memRspData[ADDR_W-1:OFF_W], addrQ[OFF_W-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      writeQ    <= 1'b0;
      userQ     <= 1'b0;
      bigEnQ    <= 1'b0;
      baseQ     <= '0;
      dirEntryQ <= '0;
    end else begin
      if (strobes.captureReq) begin
        addrQ  <= reqAddr;
        writeQ <= reqWrite;
        userQ  <= reqUser;
        bigEnQ <= bigPageOn;
        baseQ  <= dirBase[ADDR_W-1:OFF_W];
      end
      if (strobes.keepDir) dirEntryQ <= memRspData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physQ  <= '0;
      faultQ <= 1'b0;
      causeQ <= CAUSE_NONE;
    end else if (strobes.finishBypass) begin
      physQ  <= reqAddr;
      faultQ <= 1'b0;
      causeQ <= CAUSE_NONE;
    end else if (strobes.finishAbsent) begin
      physQ  <= '0;
      faultQ <= 1'b1;
      causeQ <= CAUSE_ABSENT;
    end else if (strobes.finishDir) begin
      physQ  <= (dirVerdict == CAUSE_NONE) ? bigPhys : '0;
      faultQ <= (dirVerdict != CAUSE_NONE);
      causeQ <= dirVerdict;
    end else if (strobes.finishTbl) begin
      physQ  <= (tblVerdict == CAUSE_NONE) ? smallPhys : '0;
      faultQ <= (tblVerdict != CAUSE_NONE);
      causeQ <= tblVerdict;
    end
  end

  assign donePhys  = physQ;
  assign doneFault = faultQ;
  assign doneCause = causeQ;

endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int TBL_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [ADDR_W-1:0] dirBase,
  input  logic              pagingOn,
  input  logic              bigPageOn,
  output logic              doneValid,
  output logic [ADDR_W-1:0] donePhys,
  output logic              doneFault,
  output logic [1:0]        doneCause,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData
);

  walkStrobes_t strobes;
  logic         rspPresent, rspBig;

  page_walk_ctrl ctrlInst (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pagingOn(pagingOn),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .rspPresent(rspPresent), .rspBig(rspBig), .reqReady(reqReady),
    .memReqValid(memReqValid), .doneValid(doneValid), .strobes(strobes)
  );

  page_walk_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TBL_W(TBL_W)) dpInst (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .dirBase(dirBase),
    .bigPageOn(bigPageOn), .memRspData(memRspData), .memReqAddr(memReqAddr),
    .rspPresent(rspPresent), .rspBig(rspBig), .donePhys(donePhys),
    .doneFault(doneFault), .doneCause(doneCause)
  );

endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              pagingOn,
  input logic              doneValid,
  input logic              doneFault,
  input logic [1:0]        doneCause,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr
);

  logic bypassQ;
  always_ff @(posedge clk) begin
    if (!rstN)                    bypassQ <= 1'b0;
    else if (reqValid && reqReady) bypassQ <= !pagingOn;
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R12
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R2
  bypass_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !pagingOn |=> doneValid && !memReqValid);

  // R2
  bypass_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    bypassQ && !reqReady |-> !memReqValid);

  // R4
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneFault |-> doneCause != 2'd0);

  // R9
  clean_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && !doneFault |-> doneCause == 2'd0);

endmodule

bind page_walker page_walker_chk #(.ADDR_W(ADDR_W)) chkInst (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .pagingOn(pagingOn), .doneValid(doneValid), .doneFault(doneFault),
  .doneCause(doneCause), .memReqValid(memReqValid), .memReqReady(memReqReady),
  .memReqAddr(memReqAddr)
);

// File: tb/page_walker_test.sv
module page_walker_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqWrite, reqUser, pagingOn, bigPageOn;
  logic        reqReady, doneValid, doneFault, memReqValid;
  logic [31:0] reqAddr, dirBase, donePhys, memReqAddr;
  logic [1:0]  doneCause;
  logic        memReqReady, memRspValid;
  logic [31:0] memRspData;

  int checkCount = 0;
  int failCount  = 0;

  logic [31:0] memModel [logic [31:0]];
  int          readCount;
  logic [31:0] readAddrs [2];
  int          readyWait = 0;
  int          rspDelay  = 0;
  int          phase = 0, grantCnt = 0, rspCnt = 0;
  logic [31:0] pendAddr;

  always #5 clk = ~clk;

  page_walker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .dirBase(dirBase), .pagingOn(pagingOn), .bigPageOn(bigPageOn),
    .doneValid(doneValid), .donePhys(donePhys), .doneFault(doneFault),
    .doneCause(doneCause), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  // Memory responder with programmable ready and data latency
  always @(negedge clk) begin
    if (!rstN) begin
      phase = 0; grantCnt = 0; rspCnt = 0;
      memReqReady = 1'b0; memRspValid = 1'b0; memRspData = '0;
    end else begin
      case (phase)
        0: if (memReqValid) begin
             if (grantCnt >= readyWait) begin
               memReqReady = 1'b1;
               pendAddr = memReqAddr;
               if (readCount < 2) readAddrs[readCount] = memReqAddr;
               readCount++;
               grantCnt = 0;
               phase = 1;
             end else grantCnt++;
           end
        1: begin
             memReqReady = 1'b0;
             if (rspCnt >= rspDelay) begin
               memRspValid = 1'b1;
               memRspData = memModel.exists(pendAddr) ? memModel[pendAddr] : 32'h0;
               rspCnt = 0;
               phase = 2;
             end else rspCnt++;
           end
        default: begin
             memRspValid = 1'b0;
             phase = 0;
           end
      endcase
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
  endtask

  // One translation; checks result, read count and handshake timing
  task automatic translate(input string tag, input logic [31:0] addr,
                           input logic wr, input logic usr,
                           input logic [31:0] expPhys, input logic expFault,
                           input logic [1:0] expCause, input int expReads);
    int waited = 0;
    readCount = 0;
    @(negedge clk);
    reqAddr = addr; reqWrite = wr; reqUser = usr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (!pagingOn)
      check({tag, " R2 done one cycle after accept"}, 32'(doneValid), 32'd1);
    else
      check({tag, " R12 busy after accept"}, 32'(reqReady), 32'd0);
    while (!doneValid && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    check({tag, " phys"},  donePhys, expPhys);
    check({tag, " fault"}, 32'(doneFault), 32'(expFault));
    check({tag, " cause"}, 32'(doneCause), 32'(expCause));
    check({tag, " reads"}, 32'(readCount), 32'(expReads));
    @(negedge clk);
    check({tag, " R12 single pulse"}, 32'(doneValid), 32'd0);
  endtask

  task automatic testReset;
    check("R1 reqReady", 32'(reqReady), 32'd1);
    check("R1 doneValid", 32'(doneValid), 32'd0);
    check("R1 memReqValid", 32'(memReqValid), 32'd0);
  endtask

  task automatic testBypass;
    pagingOn = 1'b0;
    translate("R2 bypass", 32'hDEAD_BEEF, 1'b1, 1'b1, 32'hDEAD_BEEF, 1'b0, 2'd0, 0);
    pagingOn = 1'b1;
  endtask

  task automatic testSmallPage;
    translate("R3 small page", 32'h0040_3123, 1'b1, 1'b1, 32'h0ABC_D123, 1'b0, 2'd0, 2);
    check("R3 directory read address", readAddrs[0], 32'h0010_0004);
    check("R3 table read address", readAddrs[1], 32'h0020_000C);
  endtask

  task automatic testAbsent;
    translate("R4 directory absent", 32'h0080_0000, 1'b0, 1'b0, 32'h0, 1'b1, 2'd1, 1);
    translate("R5 table absent", 32'h0040_5000, 1'b0, 1'b0, 32'h0, 1'b1, 2'd1, 2);
  endtask

  task automatic testLargePage;
    bigPageOn = 1'b1;
    translate("R6 large page", 32'h0C12_3456, 1'b1, 1'b1, 32'h1412_3456, 1'b0, 2'd0, 1);
    bigPageOn = 1'b0;
    translate("R7 size bit ignored", 32'h0C12_3456, 1'b1, 1'b1, 32'h0055_5456, 1'b0, 2'd0, 2);
    check("R7 table read address", readAddrs[1], 32'h1400_048C);
  endtask

  task automatic testPrivilege;
    translate("R8 user to supervisor page", 32'h0040_7010, 1'b0, 1'b1, 32'h0, 1'b1, 2'd2, 2);
    translate("R8 supervisor access", 32'h0040_7010, 1'b0, 1'b0, 32'h0077_7010, 1'b0, 2'd0, 2);
  endtask

  task automatic testWriteProtect;
    translate("R9 user write read-only", 32'h0040_8020, 1'b1, 1'b1, 32'h0, 1'b1, 2'd3, 2);
    translate("R9 user read read-only", 32'h0040_8020, 1'b0, 1'b1, 32'h0088_8020, 1'b0, 2'd0, 2);
    translate("R9 supervisor write", 32'h0040_8020, 1'b1, 1'b0, 32'h0088_8020, 1'b0, 2'd0, 2);
    translate("R9 priority privilege first", 32'h0040_9000, 1'b1, 1'b1, 32'h0, 1'b1, 2'd2, 2);
  endtask

  task automatic testCombinedRights;
    translate("R10 directory denies user", 32'h00C0_1000, 1'b0, 1'b1, 32'h0, 1'b1, 2'd2, 2);
    translate("R10 supervisor through same", 32'h00C0_1000, 1'b1, 1'b0, 32'h0099_9000, 1'b0, 2'd0, 2);
  endtask

  task automatic testSlowMemory;
    readyWait = 5; rspDelay = 7;
    translate("R11 slow memory", 32'h0040_3123, 1'b0, 1'b1, 32'h0ABC_D123, 1'b0, 2'd0, 2);
    readyWait = 0; rspDelay = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqWrite = 1'b0; reqUser = 1'b0;
    dirBase = 32'h0010_0ABC; pagingOn = 1'b1; bigPageOn = 1'b0; readCount = 0;
    memModel[32'h0010_0004] = 32'h0020_0007;   // directory 1 -> table at 0x00200000
    memModel[32'h0020_000C] = 32'h0ABC_D007;
    memModel[32'h001_000C0] = 32'h1400_0087;   // directory 0x30, size bit set
    memModel[32'h1400_048C] = 32'h0055_5007;
    memModel[32'h0020_001C] = 32'h0077_7003;   // supervisor only
    memModel[32'h0020_0020] = 32'h0088_8005;   // read-only, user allowed
    memModel[32'h0020_0024] = 32'h00AA_A001;   // present only
    memModel[32'h0010_000C] = 32'h0030_0003;   // directory 3 denies user
    memModel[32'h0030_0004] = 32'h0099_9007;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBypass();
    testSmallPage();
    testAbsent();
    testLargePage();
    testPrivilege();
    testWriteProtect();
    testCombinedRights();
    testSlowMemory();
    summary();
    $finish;
  end

endmodule